// File: doc/BRIEF.md
# Dual-Bank SDRAM Command Legality Checker

This block watches the command pins of a two-bank synchronous DRAM. It tracks the state of each bank and of the power mode, and flags every command that is not allowed in the current state. A controller under test or a bus monitor drives the same clock enable, chip select, row strobe, column strobe, write enable, bank select and auto-precharge address bit that the memory would see. The block then reports each bank's state, a combined idle flag, and a one-cycle error pulse with a code that names the broken rule.

The transient states of a bank are timed by a per-bank down-counter: activating, write-recovering, auto-precharging, precharging, refreshing and mode-setting. The timing limits are cycle-count parameters: row-to-column delay, activate-to-activate spacing, precharge time, refresh cycle time, mode-set time, write recovery and burst length. An illegal command changes no bank state and no power mode. The counters that are already running keep counting. The data path and the memory array are not modelled.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset both bank states are 0 (idle), pwr_mode is 0 (normal), all_idle is 1, illegal is 0 and err_code is 0.
- R2: A command is taken from {ras_n,cas_n,we_n} only when cs_n is low, pwr_mode is normal and cke was high in the previous cycle. The encodings are 000 mode set, 001 refresh, 011 activate, 010 precharge, 101 read, 100 write, 110 burst stop and 111 no-op. Commands taken while cke was low in the previous cycle are ignored.
- R3: An activate to an idle bank moves it to state 1 (activating) for T_RCD cycles, then to state 2 (active). A read or write to a bank that is not active or write-recovering gives err_code 3. An activate to a bank that is not idle gives err_code 1.
- R4: An activate issued fewer than T_RRD cycles after the previous activate gives err_code 2.
- R5: A write with a8 low moves the bank to state 3 (write-recovering) for BURST+T_RDL-1 cycles, then back to active. A precharge that targets it during that time gives err_code 4.
- R6: A read with a8 high holds the bank in state 4 (auto-precharge) for BURST cycles; a write with a8 high holds it there for BURST+T_RDL-1 cycles. The bank then spends T_RP cycles in state 5 (precharging) and returns to idle. An activate to it meanwhile gives err_code 1, a read or write gives err_code 3, and a precharge gives err_code 4.
- R7: A precharge with a8 low targets the bank given by ba; with a8 high it targets both banks. An active bank goes to precharging for T_RP cycles. An idle or precharging bank is left unchanged and the command is legal. If any targeted bank is activating, write-recovering or auto-precharging, err_code 4 results.
- R8: Refresh and mode set need both banks idle, otherwise err_code 5. A refresh puts both banks in state 6 for T_RC cycles. A mode set puts both banks in state 7 for T_RSC cycles. Any command other than a no-op or deselect during states 6 or 7, or cke falling during them, gives err_code 7, which takes priority over all other codes.
- R9: When cke falls during a no-op or deselect and both banks are idle, pwr_mode becomes 1 (power-down). Commands are ignored while in power-down. cke high returns pwr_mode to 0.
- R10: When cke falls during a refresh command and both banks are idle, pwr_mode becomes 2 (self-refresh). Commands are ignored while in self-refresh. cke high returns pwr_mode to 0 and puts both banks in state 6 for T_RC cycles.
- R11: When cke falls during any command other than no-op, deselect or refresh, err_code 6 results. When cke falls during a no-op, deselect or refresh while a bank is not idle, err_code 5 results. In both cases pwr_mode stays 0.
- R12: illegal and err_code are registered: they appear one cycle after the offending command and last one cycle per illegal command. A burst stop is legal outside states 6 and 7 and changes no state.
- R13: all_idle is 1 exactly when both bank states are 0 and pwr_mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen by the memory |
| cs_n | input | 1 | Chip select, active low; high is a deselect |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable |
| ba | input | 1 | Bank select for activate, read, write and single precharge |
| a8 | input | 1 | Auto-precharge on read/write, all-banks on precharge |
| bank0_state | output | 3 | State of bank 0 (0 idle to 7 mode-setting) |
| bank1_state | output | 3 | State of bank 1 |
| pwr_mode | output | 2 | 0 normal, 1 power-down, 2 self-refresh |
| all_idle | output | 1 | Both banks idle in normal mode |
| illegal | output | 1 | One-cycle pulse for an illegal command |
| err_code | output | 3 | Reason for the pulse, 0 when none |

## Verification
Each command is sampled on a rising edge. The bank states, the power mode, the illegal pulse and err_code all reflect it right after that same edge, so every result is due one clock after the command is presented. The bench drives each command on the falling edge and pushes its expected outputs into a queue. A monitor pops one entry 2 ns after each rising edge, which keeps exactly one expectation per clock. Timer boundaries are exercised cycle by cycle: for example a precharge rejected during write recovery and accepted on the first allowed edge, and an activate rejected inside the activate-to-activate window. The cycles with cke low are covered as well; there the command must be ignored.

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard #(
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_RP  = 3,
  parameter int T_RC  = 4,
  parameter int T_RSC = 2,
  parameter int T_RDL = 2,
  parameter int BURST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       ba,
  input  logic       a8,
  output logic [2:0] bank0_state,
  output logic [2:0] bank1_state,
  output logic [1:0] pwr_mode,
  output logic       all_idle,
  output logic       illegal,
  output logic [2:0] err_code
);

  localparam int M1   = (T_RCD > T_RRD) ? T_RCD : T_RRD;
  localparam int M2   = (M1 > T_RP) ? M1 : T_RP;
  localparam int M3   = (M2 > T_RC) ? M2 : T_RC;
  localparam int M4   = (M3 > T_RSC) ? M3 : T_RSC;
  localparam int TMAX = (M4 > BURST + T_RDL) ? M4 : BURST + T_RDL;
  localparam int CW   = $clog2(TMAX + 1);

  localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_RRD = CW'(T_RRD - 1);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
  localparam logic [CW-1:0] L_RSC = CW'(T_RSC - 1);
  localparam logic [CW-1:0] L_WR  = CW'(BURST + T_RDL - 2);
  localparam logic [CW-1:0] L_RDA = CW'(BURST - 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_ACTG = 3'd1, S_OPEN = 3'd2, S_WREC = 3'd3,
                         S_AUTO = 3'd4, S_PCHG = 3'd5, S_RFSH = 3'd6, S_MSET = 3'd7;
  localparam logic [1:0] M_RUN = 2'd0, M_PDN = 2'd1, M_SELF = 2'd2;
  localparam logic [2:0] E_NONE = 3'd0, E_BANK = 3'd1, E_RRD = 3'd2, E_COL = 3'd3,
                         E_PRE = 3'd4, E_IDLE = 3'd5, E_CKE = 3'd6, E_BUSY = 3'd7;

  logic [2:0]    st   [2];
  logic [CW-1:0] cnt  [2];
  logic [2:0]    eff  [2];
  logic [2:0]    nst  [2];
  logic [CW-1:0] ncnt [2];
  logic [CW-1:0] rrd;
  logic [1:0]    mode;
  logic          cke_q;
  logic [2:0]    code;

  function automatic logic [2:0] settle(input logic [2:0] s, input logic [CW-1:0] c);
    if (c != '0) return s;
    case (s)
      S_ACTG, S_WREC:         return S_OPEN;
      S_PCHG, S_RFSH, S_MSET: return S_IDLE;
      default:                return s;
    endcase
  endfunction

  function automatic logic pre_ok(input logic [2:0] s);
    return (s == S_IDLE) || (s == S_OPEN) || (s == S_PCHG);
  endfunction

  assign eff[0] = settle(st[0], cnt[0]);
  assign eff[1] = settle(st[1], cnt[1]);

  wire [2:0] op      = {ras_n, cas_n, we_n};
  wire       cmd_on  = (mode == M_RUN) && cke_q;
  wire       sel     = cmd_on && !cs_n;
  wire       is_mrs  = sel && (op == 3'b000);
  wire       is_ref  = sel && (op == 3'b001);
  wire       is_act  = sel && (op == 3'b011);
  wire       is_pre  = sel && (op == 3'b010);
  wire       is_rd   = sel && (op == 3'b101);
  wire       is_wr   = sel && (op == 3'b100);
  wire       any_cmd = sel && (op != 3'b111);
  wire       cke_fall = cmd_on && !cke;
  wire       sr_exit  = (mode == M_SELF) && cke;
  wire [2:0] tgt      = eff[ba];
  wire       both_idle = (eff[0] == S_IDLE) && (eff[1] == S_IDLE);
  wire       busy = (eff[0] == S_RFSH) || (eff[0] == S_MSET) ||
                    (eff[1] == S_RFSH) || (eff[1] == S_MSET);
  wire       ok = (code == E_NONE);

  always_comb begin
    code = E_NONE;
    if (busy && (any_cmd || cke_fall)) code = E_BUSY;
    else if (cke_fall) begin
      if (any_cmd && !is_ref) code = E_CKE;
      else if (!both_idle)    code = E_IDLE;
    end else if (is_act) begin
      if (tgt != S_IDLE)  code = E_BANK;
      else if (rrd != '0) code = E_RRD;
    end else if (is_rd || is_wr) begin
      if (tgt != S_OPEN && tgt != S_WREC) code = E_COL;
    end else if (is_pre) begin
      if (a8 ? !(pre_ok(eff[0]) && pre_ok(eff[1])) : !pre_ok(tgt)) code = E_PRE;
    end else if (is_ref || is_mrs) begin
      if (!both_idle) code = E_IDLE;
    end
  end

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      nst[b]  = eff[b];
      ncnt[b] = (cnt[b] != '0) ? cnt[b] - CW'(1) : '0;
      if (st[b] == S_AUTO && cnt[b] == '0) begin
        nst[b] = S_PCHG; ncnt[b] = L_RP;
      end
      if (sr_exit) begin
        nst[b] = S_RFSH; ncnt[b] = L_RC;
      end else if (ok) begin
        if (is_ref && !cke_fall) begin
          nst[b] = S_RFSH; ncnt[b] = L_RC;
        end else if (is_mrs) begin
          nst[b] = S_MSET; ncnt[b] = L_RSC;
        end else if (is_act && ba == 1'(b)) begin
          nst[b] = S_ACTG; ncnt[b] = L_RCD;
        end else if (is_rd && ba == 1'(b) && a8) begin
          nst[b] = S_AUTO; ncnt[b] = L_RDA;
        end else if (is_wr && ba == 1'(b)) begin
          nst[b] = a8 ? S_AUTO : S_WREC; ncnt[b] = L_WR;
        end else if (is_pre && (a8 || ba == 1'(b)) && eff[b] == S_OPEN) begin
          nst[b] = S_PCHG; ncnt[b] = L_RP;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st[0] <= S_IDLE; st[1] <= S_IDLE;
      cnt[0] <= '0;    cnt[1] <= '0;
      rrd <= '0;
      mode <= M_RUN;
      cke_q <= 1'b1;
      illegal <= 1'b0;
      err_code <= E_NONE;
    end else begin
      st[0] <= nst[0];   st[1] <= nst[1];
      cnt[0] <= ncnt[0]; cnt[1] <= ncnt[1];
      cke_q <= cke;
      illegal <= !ok;
      err_code <= code;
      if (ok && is_act)  rrd <= L_RRD;
      else if (rrd != '0) rrd <= rrd - CW'(1);
      case (mode)
        M_RUN:   if (cke_fall && ok) mode <= is_ref ? M_SELF : M_PDN;
        default: if (cke) mode <= M_RUN;
      endcase
    end
  end

  assign bank0_state = st[0];
  assign bank1_state = st[1];
  assign pwr_mode    = mode;
  assign all_idle    = (st[0] == S_IDLE) && (st[1] == S_IDLE) && (mode == M_RUN);

endmodule

// File: rtl/sdram_cmd_guard_chk.sv
module sdram_cmd_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bank0_state,
  input logic [2:0] bank1_state,
  input logic [1:0] pwr_mode,
  input logic       illegal
);

  // R3
  act_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank0_state == 3'd1 && $past(bank0_state) != 3'd1) |-> $past(bank0_state) == 3'd0);

  // R6
  auto_from_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank1_state == 3'd4 && $past(bank1_state) != 3'd4) |->
      ($past(bank1_state) inside {3'd1, 3'd2, 3'd3}));

  // R12
  illegal_keeps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && $past(bank0_state) == 3'd0) |-> bank0_state == 3'd0);

  // R8
  refresh_joint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank0_state == 3'd6) |-> bank1_state == 3'd6);

  // R9
  lowpower_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 2'd0) |-> (bank0_state == 3'd0 && bank1_state == 3'd0));

  // R10
  selfref_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_mode) == 2'd2 && pwr_mode == 2'd0) |-> (bank0_state == 3'd6 && bank1_state == 3'd6));

endmodule

bind sdram_cmd_guard sdram_cmd_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bank0_state(bank0_state), .bank1_state(bank1_state),
  .pwr_mode(pwr_mode), .illegal(illegal)
);

// File: tb/sdram_cmd_guard_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_guard_tb_top;

  localparam int C_NOP = 0, C_DES = 1, C_ACT = 2, C_RD = 3, C_WR = 4,
                 C_PRE = 5, C_BST = 6, C_REF = 7, C_MRS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ba = 1'b0, a8 = 1'b0;
  logic [2:0] bank0_state, bank1_state, err_code;
  logic [1:0] pwr_mode;
  logic all_idle, illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic  ill;
    int    code;
    int    s0;
    int    s1;
    int    m;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  sdram_cmd_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a8(a8), .bank0_state(bank0_state), .bank1_state(bank1_state),
    .pwr_mode(pwr_mode), .all_idle(all_idle), .illegal(illegal), .err_code(err_code)
  );

  task automatic compare(input exp_t e);
    logic exp_idle;
    exp_idle = (e.s0 == 0) && (e.s1 == 0) && (e.m == 0);
    checks++;
    if (illegal !== e.ill || err_code !== 3'(e.code) || bank0_state !== 3'(e.s0) ||
        bank1_state !== 3'(e.s1) || pwr_mode !== 2'(e.m) || all_idle !== exp_idle) begin
      errors++;
      $display("FAIL %s: got ill=%0d code=%0d b0=%0d b1=%0d mode=%0d idle=%0d, expected ill=%0d code=%0d b0=%0d b1=%0d mode=%0d idle=%0d",
               e.tag, illegal, err_code, bank0_state, bank1_state, pwr_mode, all_idle,
               e.ill, e.code, e.s0, e.s1, e.m, exp_idle);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  task automatic step(input int c, input logic b, input logic a, input logic k,
                      input logic ei, input int ec, input int e0, input int e1,
                      input int em, input string tag);
    exp_t e;
    @(negedge clk);
    cke = k; ba = b; a8 = a;
    cs_n = (c == C_DES);
    case (c)
      C_MRS:   {ras_n, cas_n, we_n} = 3'b000;
      C_REF:   {ras_n, cas_n, we_n} = 3'b001;
      C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      C_RD:    {ras_n, cas_n, we_n} = 3'b101;
      C_WR:    {ras_n, cas_n, we_n} = 3'b100;
      C_BST:   {ras_n, cas_n, we_n} = 3'b110;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    e.ill = ei; e.code = ec; e.s0 = e0; e.s1 = e1; e.m = em; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic nops(input int n, input int e0, input int e1, input string tag);
    for (int i = 0; i < n; i++) step(C_NOP, 0, 0, 1, 0, 0, e0, e1, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (bank0_state !== 3'd0 || bank1_state !== 3'd0 || pwr_mode !== 2'd0 ||
        all_idle !== 1'b1 || illegal !== 1'b0 || err_code !== 3'd0) begin
      errors++;
      $display("FAIL R1 reset: got b0=%0d b1=%0d mode=%0d idle=%0d ill=%0d code=%0d, expected 0 0 0 1 0 0",
               bank0_state, bank1_state, pwr_mode, all_idle, illegal, err_code);
    end

    step(C_NOP, 0, 0, 1, 0, 0, 0, 0, 0, "R13 idle flag");
    step(C_RD,  0, 0, 1, 1, 3, 0, 0, 0, "R3 read to closed bank");
    step(C_ACT, 0, 0, 1, 0, 0, 1, 0, 0, "R3 activate bank0");
    step(C_ACT, 1, 0, 1, 1, 2, 1, 0, 0, "R4 activate inside spacing");
    step(C_RD,  0, 0, 1, 1, 3, 1, 0, 0, "R3 read before row delay");
    step(C_ACT, 1, 0, 1, 0, 0, 2, 1, 0, "R4 activate after spacing");
    step(C_WR,  0, 0, 1, 0, 0, 3, 1, 0, "R5 write enters recovery");
    step(C_PRE, 0, 0, 1, 1, 4, 3, 1, 0, "R5 precharge during recovery");
    nops(3, 3, 2, "R5 recovery holds");
    step(C_PRE, 0, 0, 1, 0, 0, 5, 2, 0, "R5 precharge after recovery");
    step(C_ACT, 0, 0, 1, 1, 1, 5, 2, 0, "R3 activate precharging bank");
    step(C_REF, 0, 0, 1, 1, 5, 5, 2, 0, "R8 refresh with open bank");
    step(C_RD,  1, 1, 1, 0, 0, 0, 4, 0, "R6 read with auto-precharge");
    step(C_WR,  1, 0, 1, 1, 3, 0, 4, 0, "R6 write to auto-precharge bank");
    step(C_PRE, 1, 0, 1, 1, 4, 0, 4, 0, "R6 precharge to auto-precharge bank");
    nops(1, 0, 4, "R6 burst continues");
    nops(3, 0, 5, "R6 internal precharge");
    step(C_ACT, 1, 0, 1, 0, 0, 0, 1, 0, "R6 activate after auto-precharge");
    step(C_PRE, 0, 1, 1, 1, 4, 0, 1, 0, "R7 precharge-all hits activating bank");
    nops(1, 0, 1, "R3 still activating");
    nops(1, 0, 2, "R3 active after row delay");
    step(C_WR,  1, 1, 1, 0, 0, 0, 4, 0, "R6 write with auto-precharge");
    step(C_BST, 0, 0, 1, 0, 0, 0, 4, 0, "R12 burst stop legal");
    nops(3, 0, 4, "R6 write auto-precharge holds");
    nops(3, 0, 5, "R6 write auto-precharge precharging");
    step(C_MRS, 0, 0, 1, 0, 0, 7, 7, 0, "R8 mode set");
    step(C_ACT, 0, 0, 1, 1, 7, 7, 7, 0, "R8 activate during mode set");
    nops(1, 0, 0, "R8 mode set done");
    step(C_REF, 0, 0, 1, 0, 0, 6, 6, 0, "R8 refresh");
    step(C_BST, 0, 0, 1, 1, 7, 6, 6, 0, "R12 burst stop during refresh");
    nops(2, 6, 6, "R8 refresh holds");
    nops(1, 0, 0, "R8 refresh done");
    step(C_NOP, 0, 0, 0, 0, 0, 0, 0, 1, "R9 power-down entry");
    step(C_ACT, 0, 0, 0, 0, 0, 0, 0, 1, "R2 command ignored in power-down");
    step(C_NOP, 0, 0, 1, 0, 0, 0, 0, 0, "R9 power-down exit");
    step(C_ACT, 0, 0, 1, 0, 0, 1, 0, 0, "R3 activate after exit");
    step(C_NOP, 0, 0, 0, 1, 5, 1, 0, 0, "R11 power-down with busy bank");
    step(C_RD,  0, 0, 0, 0, 0, 1, 0, 0, "R2 command ignored cke low");
    step(C_NOP, 0, 0, 1, 0, 0, 2, 0, 0, "R2 cke low previous cycle");
    step(C_PRE, 0, 0, 1, 0, 0, 5, 0, 0, "R7 precharge open bank");
    step(C_RD,  0, 0, 0, 1, 6, 5, 0, 0, "R11 cke drop with read");
    step(C_NOP, 0, 0, 1, 0, 0, 5, 0, 0, "R2 ignored after cke low");
    nops(1, 0, 0, "R7 precharge done");
    step(C_REF, 0, 0, 0, 0, 0, 0, 0, 2, "R10 self-refresh entry");
    step(C_ACT, 0, 0, 0, 0, 0, 0, 0, 2, "R10 command ignored in self-refresh");
    step(C_NOP, 0, 0, 1, 0, 0, 6, 6, 0, "R10 self-refresh exit");
    step(C_ACT, 0, 0, 1, 1, 7, 6, 6, 0, "R10 activate after exit too early");
    nops(2, 6, 6, "R10 exit refresh holds");
    nops(1, 0, 0, "R13 idle again");
    step(C_ACT, 0, 0, 1, 0, 0, 1, 0, 0, "R3 activate bank0");
    nops(2, 1, 0, "R3 activating");
    nops(1, 2, 0, "R3 active");
    step(C_ACT, 1, 0, 1, 0, 0, 2, 1, 0, "R4 second bank");
    nops(2, 2, 1, "R3 activating bank1");
    nops(1, 2, 2, "R3 both open");
    step(C_PRE, 0, 1, 1, 0, 0, 5, 5, 0, "R7 precharge-all");
    nops(2, 5, 5, "R7 precharging");
    nops(1, 0, 0, "R7 both idle");
    step(C_PRE, 1, 0, 1, 0, 0, 0, 0, 0, "R7 precharge idle bank");
    nops(2, 0, 0, "R13 tail");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule